// File: doc/BRIEF.md
# Bidirectional Shift Register with Parallel Load

This block is a small register whose operation on each rising clock edge comes from a two-bit mode code. The four operations are: keep the stored value, move every bit one place toward the MSB, move every bit one place toward the LSB, or capture a full parallel word. A per-bit four-input multiplexer picks the next value of each bit. The choices are the bit's own value, the bit below it, the bit above it and the matching parallel input bit.

Serial data enters the end that a shift leaves empty. The left serial input fills the LSB during a left shift. During a right shift, a variant select decides what fills the MSB. In logical form the right serial input fills the MSB. In arithmetic form the old MSB stays in place, so a two's-complement value is halved with its sign kept. A synchronous clear returns the register to zero and overrides the mode.

Top module: `bidir_shreg`

## Requirements
- R1: When `clr` is 1 at a rising edge, `q` becomes all zeros after that edge, whatever `mode`, `arith`, `d` and the serial inputs are.
- R2: With `clr`=0 and `mode`=2'b00 (hold), `q` keeps its value across the edge.
- R3: With `clr`=0 and `mode`=2'b01 (left), bit i of `q` takes the old bit i-1, and bit 0 takes `ser_left`.
- R4: With `clr`=0, `mode`=2'b10 (right) and `arith`=0, bit i of `q` takes the old bit i+1, and the MSB takes `ser_right`.
- R5: With `clr`=0, `mode`=2'b10 and `arith`=1, bit i of `q` takes the old bit i+1, the MSB keeps its old value, and `ser_right` has no effect.
- R6: With `clr`=0 and `mode`=2'b11 (load), `q` takes `d` in full.
- R7: `arith` has no effect unless `mode`=2'b10. `ser_left` has no effect unless `mode`=2'b01. `d` has no effect unless `mode`=2'b11.
- R8: `q` changes only at a rising edge of `clk`. Input changes between edges do not show on `q` until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the register updates on the rising edge |
| clr | input | 1 | Synchronous clear, active high, overrides the mode |
| mode | input | 2 | Operation: 00 hold, 01 left, 10 right, 11 load |
| arith | input | 1 | Right-shift variant: 0 logical, 1 arithmetic |
| ser_left | input | 1 | Serial bit that enters the LSB during a left shift |
| ser_right | input | 1 | Serial bit that enters the MSB during a logical right shift |
| d | input | W (4) | Parallel load word |
| q | output | W (4) | Register contents |

## Verification
A wrong multiplexer select or a wrong neighbour connection at any bit shows on `q` right after the edge where that operation is used. Each check compares `q` one edge after the stimulus with a value computed independently. A wrong end-fill shows only at bit 0 or at the MSB, so the shift tests walk patterns that put both a 0 and a 1 into each end. Corruption that only appears under a later hold is caught because the value held over several edges is compared again after each edge.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'b00,
    OP_LEFT  = 2'b01,
    OP_RIGHT = 2'b10,
    OP_LOAD  = 2'b11
  } shreg_op_e;

  // Value entering the MSB on a right shift.
  function automatic logic msb_entry(input logic arith, input logic old_msb,
                                     input logic ser_in);
    return arith ? old_msb : ser_in;
  endfunction

  // Four-way pick used at every bit position.
  function automatic logic pick4(input logic [1:0] sel, input logic keep,
                                 input logic lower, input logic upper,
                                 input logic par);
    logic r;
    unique case (sel)
      OP_HOLD:  r = keep;
      OP_LEFT:  r = lower;
      OP_RIGHT: r = upper;
      default:  r = par;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/shreg_endfill.sv
module shreg_endfill (
  input  logic arith,
  input  logic old_msb,
  input  logic ser_left,
  input  logic ser_right,
  output logic lsb_in,
  output logic msb_in
);
  import shreg_pkg::*;
  always_comb begin
    lsb_in = ser_left;
    msb_in = msb_entry(arith, old_msb, ser_right);
  end
endmodule

// File: rtl/shreg_mux4.sv
module shreg_mux4 (
  input  logic [1:0] sel,
  input  logic       keep,
  input  logic       lower,
  input  logic       upper,
  input  logic       par,
  output logic       y
);
  import shreg_pkg::*;
  always_comb y = pick4(sel, keep, lower, upper, par);
endmodule

// File: rtl/shreg_store.sv
module shreg_store #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] cur
);
  always_ff @(posedge clk) begin
    if (clr) cur <= '0;
    else     cur <= nxt;
  end
endmodule

// File: rtl/bidir_shreg.sv
module bidir_shreg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [1:0]   mode,
  input  logic         arith,
  input  logic         ser_left,
  input  logic         ser_right,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int MSB = W - 1;

  logic         lsb_in;
  logic         msb_in;
  logic [W-1:0] lower_nb;
  logic [W-1:0] upper_nb;
  logic [W-1:0] nxt;

  shreg_endfill u_fill (
    .arith     (arith),
    .old_msb   (q[MSB]),
    .ser_left  (ser_left),
    .ser_right (ser_right),
    .lsb_in    (lsb_in),
    .msb_in    (msb_in)
  );

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lo
      assign lower_nb[i] = lsb_in;
    end else begin : g_lo_mid
      assign lower_nb[i] = q[i-1];
    end
    if (i == MSB) begin : g_hi
      assign upper_nb[i] = msb_in;
    end else begin : g_hi_mid
      assign upper_nb[i] = q[i+1];
    end
    shreg_mux4 u_mux (
      .sel   (mode),
      .keep  (q[i]),
      .lower (lower_nb[i]),
      .upper (upper_nb[i]),
      .par   (d[i]),
      .y     (nxt[i])
    );
  end

  shreg_store #(.W(W)) u_store (
    .clk (clk),
    .clr (clr),
    .nxt (nxt),
    .cur (q)
  );
endmodule

// File: rtl/bidir_shreg_chk.sv
module bidir_shreg_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         clr,
  input logic [1:0]   mode,
  input logic         arith,
  input logic         ser_left,
  input logic         ser_right,
  input logic [W-1:0] d,
  input logic [W-1:0] q
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (clr) armed <= 1'b1;

  assert_clear_R1: assert property (@(posedge clk) disable iff (!armed)
    clr |=> (q == '0));

  assert_hold_R2: assert property (@(posedge clk) disable iff (clr || !armed)
    (mode == 2'b00) |=> (q == $past(q)));

  assert_left_R3: assert property (@(posedge clk) disable iff (clr || !armed)
    (mode == 2'b01) |=> (q == {$past(q[W-2:0]), $past(ser_left)}));

  assert_right_log_R4: assert property (@(posedge clk) disable iff (clr || !armed)
    (mode == 2'b10 && !arith) |=> (q == {$past(ser_right), $past(q[W-1:1])}));

  assert_right_arith_R5: assert property (@(posedge clk) disable iff (clr || !armed)
    (mode == 2'b10 && arith) |=> (q == {$past(q[W-1]), $past(q[W-1:1])}));

  assert_load_R6: assert property (@(posedge clk) disable iff (clr || !armed)
    (mode == 2'b11) |=> (q == $past(d)));
endmodule

bind bidir_shreg bidir_shreg_chk #(.W(W)) u_chk (
  .clk(clk), .clr(clr), .mode(mode), .arith(arith), .ser_left(ser_left),
  .ser_right(ser_right), .d(d), .q(q)
);

// File: tb/tb_bidir_shreg.sv
`timescale 1ns/1ps
module tb_bidir_shreg;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         clr = 1'b1;
  logic [1:0]   mode = 2'b00;
  logic         arith = 1'b0;
  logic         ser_left = 1'b0;
  logic         ser_right = 1'b0;
  logic [W-1:0] d = '0;
  logic [W-1:0] q;

  int checks = 0;
  int fails = 0;
  logic [W-1:0] expq = '0;

  always #2 clk = ~clk;

  bidir_shreg #(.W(W)) dut (
    .clk(clk), .clr(clr), .mode(mode), .arith(arith), .ser_left(ser_left),
    .ser_right(ser_right), .d(d), .q(q)
  );

  // Reference built from the requirement text with shift operators.
  function automatic logic [W-1:0] model(input logic [W-1:0] cur);
    logic [W-1:0] r;
    if (clr) return '0;
    case (mode)
      2'b01: r = (cur << 1) | W'(ser_left);
      2'b10: if (arith) r = W'($signed(cur) >>> 1);
             else       r = (cur >> 1) | (W'(ser_right) << (W-1));
      2'b11: r = d;
      default: r = cur;
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] want);
    checks++;
    if (q !== want) begin
      fails++;
      $display("FAIL %s: q=%b expected %b", tag, q, want);
    end
  endtask

  task automatic step(input string tag);
    expq = model(expq);
    @(posedge clk);
    #1;
    check(tag, expq);
  endtask

  task automatic drive(input logic c, input logic [1:0] m, input logic a,
                       input logic sl, input logic sr, input logic [W-1:0] dv);
    clr = c; mode = m; arith = a; ser_left = sl; ser_right = sr; d = dv;
  endtask

  task automatic t_reset();
    drive(1, 2'b11, 1, 1, 1, 4'b1111);
    step("R1 clear at start");
    drive(0, 2'b11, 0, 0, 0, 4'b1011);
    step("R6 load after clear");
    drive(1, 2'b01, 0, 1, 1, 4'b1111);
    step("R1 clear over left shift");
    drive(0, 2'b11, 0, 0, 0, 4'b0110);
    step("R6 load");
    drive(1, 2'b11, 1, 1, 1, 4'b1111);
    step("R1 clear over load");
  endtask

  task automatic t_load();
    foreach (expq[i]) begin
      drive(0, 2'b11, i[0], i[1], ~i[0], W'(4'b1001 ^ (i * 3)));
      step("R6 load pattern");
    end
  endtask

  task automatic t_hold();
    drive(0, 2'b11, 0, 0, 0, 4'b1010);
    step("R6 load before hold");
    for (int k = 0; k < 3; k++) begin
      drive(0, 2'b00, k[0], ~k[0], k[0], 4'b0101);
      step("R2 hold / R7 d and ser_left ignored");
    end
  endtask

  task automatic t_left();
    drive(0, 2'b11, 0, 0, 0, 4'b0000);
    step("R6 load zero");
    for (int k = 0; k < 6; k++) begin
      drive(0, 2'b01, k[1], (k % 3) != 2, 1, 4'b1111);
      step("R3 left shift / R7 arith and d ignored");
    end
  endtask

  task automatic t_right_log();
    drive(0, 2'b11, 0, 0, 0, 4'b1001);
    step("R6 load");
    for (int k = 0; k < 6; k++) begin
      drive(0, 2'b10, 0, 1, k[0], 4'b0110);
      step("R4 logical right / R7 ser_left and d ignored");
    end
  endtask

  task automatic t_right_arith();
    drive(0, 2'b11, 0, 0, 0, 4'b1010);
    step("R6 load negative");
    for (int k = 0; k < 4; k++) begin
      drive(0, 2'b10, 1, 0, k[0], 4'b0000);
      step("R5 arithmetic right, negative");
    end
    drive(0, 2'b11, 0, 0, 0, 4'b0110);
    step("R6 load positive");
    for (int k = 0; k < 3; k++) begin
      drive(0, 2'b10, 1, 1, 1, 4'b1111);
      step("R5 arithmetic right, positive, ser_right=1");
    end
  endtask

  task automatic t_edge();
    drive(0, 2'b11, 0, 0, 0, 4'b0011);
    step("R6 load");
    mode = 2'b01; ser_left = 1; d = 4'b1100;
    #0.5; check("R8 no change between edges (left)", expq);
    mode = 2'b11; d = 4'b1110; arith = 1;
    #0.5; check("R8 no change between edges (load)", expq);
    d = 4'b0101;
    step("R8 latest d taken at edge");
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_load();
    t_hold();
    t_left();
    t_right_log();
    t_right_arith();
    t_edge();
    t_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule